// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block guards an in-order pipeline against the case where an instruction in decode reads a register that a load, one slot ahead in execute, has not yet returned from data memory. It compares the load's target register against both source registers of the decoding instruction. On a match it freezes the program counter and the fetch-to-decode latch for one cycle. In that same cycle it zeroes the control fields loaded into the decode-to-execute latch, so the slot behind the load becomes a no-op.

The detector is purely combinational on the outputs of the two latches, so the hazard is recognised in the cycle in which it first exists. A small model of the program counter, the fetch-to-decode latch and the decode-to-execute latch is wrapped around the detector, so the stall behaviour can be observed at the ports. After a single stall cycle the load has moved into the memory stage, where a forwarding path, outside this block, can supply its result.

Control words are `CTRL_W` bits wide. Bit 0 is the memory-read flag and the other bits are opaque to this block. Register identifiers are `REG_AW` bits wide, and identifier 0 is the hard-wired zero register.

Top module: `lu_stall_top`

## Requirements
- R1: `dx_ctrl_zero` is 1 in the same cycle exactly when `ex_ctrl[0]` is 1, `ex_rd` is non-zero, and `ex_rd` equals `dec_rs1` or `dec_rs2`; otherwise it is 0. `pc_we` and `fd_we` are always the inverse of `dx_ctrl_zero`.
- R2: A load whose target `ex_rd` is 0 never causes a stall, even when a decode source register is also 0.
- R3: When `pc_we` is 0 at a rising edge, `pc_q` keeps its value; otherwise `pc_q` advances by `PC_STEP` (default 4).
- R4: When `fd_we` is 0 at a rising edge, `dec_rs1`, `dec_rs2`, `dec_rd` and `dec_ctrl` keep their values, and the fetch inputs of that cycle are ignored.
- R5: When `dx_ctrl_zero` is 1 at a rising edge, `ex_ctrl` is all zeros after that edge, while `ex_rd` still takes `dec_rd`.
- R6: With no stall, a rising edge moves the fetch inputs into the `dec_*` outputs, and moves `dec_rd` and `dec_ctrl` into `ex_rd` and `ex_ctrl`.
- R7: A stall lasts exactly one cycle: a cycle with `dx_ctrl_zero` 1 is always followed by one with `dx_ctrl_zero` 0.
- R8: A rising edge with `rst_n` low clears `pc_q`, all `dec_*` and `ex_*` outputs. While `rst_n` is low, `dx_ctrl_zero` is 0.
- R9: An instruction in execute with `ex_ctrl[0]` 0 never causes a stall, whatever its target register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_rs1 | input | REG_AW | First source register of the fetched instruction |
| in_rs2 | input | REG_AW | Second source register of the fetched instruction |
| in_rd | input | REG_AW | Target register of the fetched instruction |
| in_ctrl | input | CTRL_W | Control word of the fetched instruction, bit 0 = memory read |
| pc_q | output | PC_W | Program counter |
| pc_we | output | 1 | Program counter write enable |
| fd_we | output | 1 | Fetch-to-decode latch write enable |
| dx_ctrl_zero | output | 1 | Zero the control fields entering the decode-to-execute latch |
| dec_rs1 | output | REG_AW | First source register held in decode |
| dec_rs2 | output | REG_AW | Second source register held in decode |
| dec_rd | output | REG_AW | Target register held in decode |
| dec_ctrl | output | CTRL_W | Control word held in decode |
| ex_rd | output | REG_AW | Target register held in execute |
| ex_ctrl | output | CTRL_W | Control word held in execute |

## Verification
On every cycle, the assertions check several invariants:
- the zero register never stalls;
- a stall only stands behind a load;
- a frozen program counter and a frozen fetch-to-decode latch stay stable;
- a stall always leaves all-zero control in execute;
- a stall never lasts two cycles in a row;
- a reset edge clears the state.

Some behaviour only the bench scenarios can show. The first is that a hazard through the second source is caught as well as one through the first. The second is that a dependence two slots apart does not stall. The third is that chained loads produce two separate single-cycle stalls. The last is that the instruction held in decode during a stall is the one that later issues. The bench shows these by comparing every port against its own behavioural pipeline model on each clock.

// File: rtl/lu_pkg.sv
// Shared widths and latch layouts for the load-use stall unit.
// Assumes two source operands per instruction and bit 0 of the control
// word marking a memory read.
package lu_pkg;
    parameter int REG_AW    = 5;
    parameter int CTRL_W    = 5;
    parameter int NUM_SRC   = 2;
    localparam int MEMRD_BIT = 0;

    typedef logic [REG_AW-1:0] reg_id_t;
    typedef logic [CTRL_W-1:0] ctrl_t;

    typedef struct packed {
        reg_id_t rd;
        reg_id_t rs2;
        reg_id_t rs1;
        ctrl_t   ctrl;
    } fd_word_t;

    typedef struct packed {
        reg_id_t rd;
        ctrl_t   ctrl;
    } dx_word_t;
endpackage

// File: rtl/lu_hazard_detect.sv
// Combinational load-use detector. Raises stall when the execute-stage
// instruction reads memory into a non-zero register that any decode-stage
// source names. Assumes its inputs come straight from latch outputs.
module lu_hazard_detect
    import lu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ctrl_t   ex_ctrl,
    input  reg_id_t ex_rd,
    input  reg_id_t dec_src [NUM_SRC],
    output logic    stall
);
    logic [NUM_SRC-1:0] src_hit;
    logic               rd_live;

    // Target register 0 is hard-wired and never carries a pending value.
    assign rd_live = (ex_rd != '0);

    genvar s;
    generate
        for (s = 0; s < NUM_SRC; s++) begin : g_src
            // One equality comparator per decode source operand.
            assign src_hit[s] = (dec_src[s] == ex_rd);
        end
    endgenerate

    // Stall only for a live load target matched by some source, never in reset.
    assign stall = rst_n & ex_ctrl[MEMRD_BIT] & rd_live & (|src_hit);

    // R2
    zero_reg_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0) |-> !stall);

    // R9
    stall_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ex_ctrl[MEMRD_BIT]);
endmodule

// File: rtl/lu_pc_reg.sv
// Program counter model. Advances by PC_STEP whenever write-enabled and
// holds otherwise. Assumes a synchronous active-low reset to address 0.
module lu_pc_reg #(
    parameter int PC_W    = 16,
    parameter int PC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    output logic [PC_W-1:0] pc_q
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    // Register the next fetch address or hold it during a stall.
    always_ff @(posedge clk) begin
        if (!rst_n)  pc_q <= '0;
        else if (we) pc_q <= pc_q + STEP;
    end

    // R3
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(pc_q));

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (pc_q == $past(pc_q) + STEP));
endmodule

// File: rtl/lu_fd_latch.sv
// Fetch-to-decode latch model. Captures the fetched instruction fields
// when write-enabled and keeps them otherwise. Clears to zero on reset.
module lu_fd_latch
    import lu_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  fd_word_t d,
    output fd_word_t q
);
    // Load or retain the decode-stage instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end

    // R4
    fd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

    // R6
    fd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(d)));
endmodule

// File: rtl/lu_dx_latch.sv
// Decode-to-execute latch model. The target register always moves on;
// the control field is forced to zero when ctrl_zero is set, which turns
// the slot into a no-op. Clears to zero on reset.
module lu_dx_latch
    import lu_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctrl_zero,
    input  dx_word_t d,
    output dx_word_t q
);
    // Advance the execute-stage word, injecting a bubble on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q.rd   <= d.rd;
            q.ctrl <= ctrl_zero ? '0 : d.ctrl;
        end
    end

    // R5
    bubble_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero |=> (q.ctrl == '0));

    // R5
    bubble_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero |=> (q.rd == $past(d.rd)));
endmodule

// File: rtl/lu_stall_top.sv
// Load-use stall unit with its pipeline-front model. The detector looks
// at the execute and decode latches and, on a hazard, freezes the PC and
// the fetch-to-decode latch while bubbling the decode-to-execute latch.
// Assumes forwarding from the memory stage covers the following cycle.
module lu_stall_top
    import lu_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int PC_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] in_rs1,
    input  logic [REG_AW-1:0] in_rs2,
    input  logic [REG_AW-1:0] in_rd,
    input  logic [CTRL_W-1:0] in_ctrl,
    output logic [PC_W-1:0]   pc_q,
    output logic              pc_we,
    output logic              fd_we,
    output logic              dx_ctrl_zero,
    output logic [REG_AW-1:0] dec_rs1,
    output logic [REG_AW-1:0] dec_rs2,
    output logic [REG_AW-1:0] dec_rd,
    output logic [CTRL_W-1:0] dec_ctrl,
    output logic [REG_AW-1:0] ex_rd,
    output logic [CTRL_W-1:0] ex_ctrl
);
    fd_word_t fetch_word;
    fd_word_t fd_q;
    dx_word_t dx_d;
    dx_word_t dx_q;
    reg_id_t  dec_src [NUM_SRC];
    logic     stall;
    logic     rst_seen_q;

    // Pack the fetched fields into the fetch-to-decode layout.
    always_comb begin
        fetch_word.rs1  = in_rs1;
        fetch_word.rs2  = in_rs2;
        fetch_word.rd   = in_rd;
        fetch_word.ctrl = in_ctrl;
    end

    // Present decode sources to the detector in operand order.
    assign dec_src[0] = fd_q.rs1;
    assign dec_src[1] = fd_q.rs2;

    // Forward the decode word toward execute.
    assign dx_d.rd   = fd_q.rd;
    assign dx_d.ctrl = fd_q.ctrl;

    lu_hazard_detect u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .ex_ctrl (dx_q.ctrl),
        .ex_rd   (dx_q.rd),
        .dec_src (dec_src),
        .stall   (stall)
    );

    lu_pc_reg #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pc_we),
        .pc_q  (pc_q)
    );

    lu_fd_latch u_fd (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (fd_we),
        .d     (fetch_word),
        .q     (fd_q)
    );

    lu_dx_latch u_dx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_zero (stall),
        .d         (dx_d),
        .q         (dx_q)
    );

    // Drive the stall controls and the observable latch contents.
    assign pc_we        = ~stall;
    assign fd_we        = ~stall;
    assign dx_ctrl_zero = stall;
    assign dec_rs1      = fd_q.rs1;
    assign dec_rs2      = fd_q.rs2;
    assign dec_rd       = fd_q.rd;
    assign dec_ctrl     = fd_q.ctrl;
    assign ex_rd        = dx_q.rd;
    assign ex_ctrl      = dx_q.ctrl;

    // Remember that the last edge was a reset edge, for the reset check.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R8
    always_ff @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            reset_state_chk: assert (pc_q == '0 && fd_q == '0 && dx_q == '0);
        end
    end

    // R7
    single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dx_ctrl_zero |=> !dx_ctrl_zero);

    // R1
    stall_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dx_ctrl_zero |-> (ex_rd == dec_rs1 || ex_rd == dec_rs2));
endmodule

// File: tb/lu_stall_top_tb.sv
`timescale 1ns/1ps
module lu_stall_top_tb;
    import lu_pkg::*;

    localparam int PC_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [REG_AW-1:0] in_rs1 = '0, in_rs2 = '0, in_rd = '0;
    logic [CTRL_W-1:0] in_ctrl = '0;
    logic [PC_W-1:0]   pc_q;
    logic              pc_we, fd_we, dx_ctrl_zero;
    logic [REG_AW-1:0] dec_rs1, dec_rs2, dec_rd, ex_rd;
    logic [CTRL_W-1:0] dec_ctrl, ex_ctrl;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Behavioural reference state
    int          m_pc;
    int          m_fd_rs1, m_fd_rs2, m_fd_rd, m_fd_ctrl;
    int          m_ex_rd, m_ex_ctrl;
    bit          m_prev_stall, m_prev_rst, started;

    always #2 clk = ~clk;

    lu_stall_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rd(in_rd), .in_ctrl(in_ctrl),
        .pc_q(pc_q), .pc_we(pc_we), .fd_we(fd_we), .dx_ctrl_zero(dx_ctrl_zero),
        .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_rd(dec_rd), .dec_ctrl(dec_ctrl),
        .ex_rd(ex_rd), .ex_ctrl(ex_ctrl)
    );

    // Program: {rs1, rs2, rd, ctrl}; ctrl 5 = load, 4 = ALU, 2 = store
    task automatic prog(input int i, output int rs1, output int rs2,
                        output int rd, output int ctrl);
        case (i)
            0:  begin rs1 = 5; rs2 = 0; rd = 1; ctrl = 5; end
            1:  begin rs1 = 1; rs2 = 6; rd = 7; ctrl = 4; end  // R1 via rs1
            2:  begin rs1 = 3; rs2 = 0; rd = 2; ctrl = 5; end
            3:  begin rs1 = 4; rs2 = 2; rd = 7; ctrl = 4; end  // R1 via rs2
            4:  begin rs1 = 8; rs2 = 0; rd = 0; ctrl = 5; end
            5:  begin rs1 = 0; rs2 = 0; rd = 6; ctrl = 4; end  // R2
            6:  begin rs1 = 1; rs2 = 2; rd = 9; ctrl = 4; end
            7:  begin rs1 = 9; rs2 = 9; rd = 3; ctrl = 4; end  // R9
            8:  begin rs1 = 1; rs2 = 0; rd = 3; ctrl = 5; end
            9:  begin rs1 = 4; rs2 = 5; rd = 8; ctrl = 4; end
            10: begin rs1 = 3; rs2 = 3; rd = 8; ctrl = 4; end  // two apart
            11: begin rs1 = 1; rs2 = 0; rd = 4; ctrl = 5; end
            12: begin rs1 = 4; rs2 = 0; rd = 5; ctrl = 5; end  // chained
            13: begin rs1 = 5; rs2 = 5; rd = 6; ctrl = 4; end
            14: begin rs1 = 6; rs2 = 7; rd = 6; ctrl = 2; end
            15: begin rs1 = 6; rs2 = 1; rd = 2; ctrl = 4; end
            default: begin
                rs1  = (i * 5 + 1) % 4;
                rs2  = (i * 3 + 2) % 4;
                rd   = (i * 7) % 4;
                ctrl = ((i * 11) % 32) | ((i % 3 == 0) ? 1 : 0);
            end
        endcase
    endtask

    task automatic chk(input string tag, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit model_stall();
        return (m_ex_ctrl % 2 == 1) && (m_ex_rd != 0) &&
               (m_ex_rd == m_fd_rs1 || m_ex_rd == m_fd_rs2);
    endfunction

    task automatic compare_all();
        bit    st;
        string stag;
        st = (rst_n == 1'b1) && model_stall();
        if (rst_n == 1'b0)           stag = "R8";
        else if (m_ex_ctrl % 2 == 0) stag = "R9";
        else if (m_ex_rd == 0)       stag = "R2";
        else                         stag = "R1";
        chk(stag, "dx_ctrl_zero", int'(dx_ctrl_zero), int'(st));
        chk("R1", "pc_we", int'(pc_we), int'(!st));
        chk("R1", "fd_we", int'(fd_we), int'(!st));
        if (m_prev_stall) chk("R7", "stall repeat", int'(dx_ctrl_zero), 0);
        chk(m_prev_rst ? "R8" : "R3", "pc_q", int'(pc_q), m_pc);
        chk(m_prev_rst ? "R8" : (m_prev_stall ? "R4" : "R6"), "dec_rs1", int'(dec_rs1), m_fd_rs1);
        chk(m_prev_rst ? "R8" : (m_prev_stall ? "R4" : "R6"), "dec_rs2", int'(dec_rs2), m_fd_rs2);
        chk(m_prev_rst ? "R8" : (m_prev_stall ? "R4" : "R6"), "dec_rd", int'(dec_rd), m_fd_rd);
        chk(m_prev_rst ? "R8" : (m_prev_stall ? "R4" : "R6"), "dec_ctrl", int'(dec_ctrl), m_fd_ctrl);
        chk(m_prev_rst ? "R8" : (m_prev_stall ? "R5" : "R6"), "ex_ctrl", int'(ex_ctrl), m_ex_ctrl);
        chk(m_prev_rst ? "R8" : (m_prev_stall ? "R5" : "R6"), "ex_rd", int'(ex_rd), m_ex_rd);
    endtask

    // One clock: compare, drive fetch inputs, then advance the model at the edge.
    task automatic step(input bit rst_val);
        int rs1, rs2, rd, ctrl;
        bit st;
        if (started) compare_all();
        prog(m_pc / 4, rs1, rs2, rd, ctrl);
        rst_n   = rst_val;
        in_rs1  = REG_AW'(rs1);
        in_rs2  = REG_AW'(rs2);
        in_rd   = REG_AW'(rd);
        in_ctrl = CTRL_W'(ctrl);
        st = rst_val && model_stall();
        @(posedge clk);
        if (!rst_val) begin
            m_pc = 0; m_fd_rs1 = 0; m_fd_rs2 = 0; m_fd_rd = 0; m_fd_ctrl = 0;
            m_ex_rd = 0; m_ex_ctrl = 0;
        end else if (st) begin
            m_ex_rd   = m_fd_rd;   // R5: target moves, control zeroed
            m_ex_ctrl = 0;
        end else begin
            m_ex_rd   = m_fd_rd;
            m_ex_ctrl = m_fd_ctrl;
            m_fd_rs1 = rs1; m_fd_rs2 = rs2; m_fd_rd = rd; m_fd_ctrl = ctrl;
            m_pc = (m_pc + 4) % (1 << PC_W);
        end
        m_prev_stall = st;
        m_prev_rst   = !rst_val;
        started      = 1;
        @(negedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        m_pc = 0; m_fd_rs1 = 0; m_fd_rs2 = 0; m_fd_rd = 0; m_fd_ctrl = 0;
        m_ex_rd = 0; m_ex_ctrl = 0; m_prev_stall = 0; m_prev_rst = 0; started = 0;
        @(negedge clk);
        repeat (3) step(1'b0);     // R8 reset state
        repeat (140) step(1'b1);   // R1..R7, R9 directed then mixed
        repeat (2) step(1'b0);     // R8 mid-run reset
        repeat (140) step(1'b1);
        step(1'b1);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule